// File: doc/BRIEF.md
# Receive Packet Ring Buffer Manager

This block keeps received words in a circular buffer of 2^AW entries held in a single-port RAM inside the block. Packets sit in the ring back to back, and each one has a length header slot in front of its data. The header slot is reserved before the frame's data arrives. When the frame ends, the block writes the frame's word count into that slot and reserves the next slot. A host read port takes words out in ring order: first the header, then the data. It stops at the slot that is reserved but not yet filled. An interrupt flag tells the host that at least one complete packet is waiting.

The receive side offers one word, or one end-of-frame, at a time. Its request is held until `rx_ack_o` is high at a rising clock edge. The host read side uses the same handshake with `rd_req_i`/`rd_ack_o`. The read data appears one cycle later, marked by `rd_valid_o`. Only one request is served per cycle: a receive word first, then end of frame, then a host read. Before any receive request is accepted, the block compares the put and get pointers modulo the ring size. If the ring is full, the request is acknowledged and discarded, and a sticky overflow flag is raised.

Top module: `rx_ring_mgr`

## Requirements
- R1: While reset is applied and after it is released, `overflow_o`, `rx_irq_o`, `rd_valid_o` and `q_pulse_o` are 0. The put, get and header-base pointers and the word count start at 0.
- R2: After reset the block writes 0 into slot 0 by itself and reserves it as the first header, leaving put at 1. This raises neither `q_pulse_o` nor `rx_irq_o`. A read that follows returns 0 and does not advance get.
- R3: A receive word or end of frame offered while (put − get) mod 2^AW equals 0 is acknowledged, sets `overflow_o`, and changes nothing else: no RAM write, no pointer or count change, no pulse and no interrupt. `overflow_o` stays 1 until reset.
- R4: An accepted receive word is written at put. Put then advances by one, and the frame's word count increases by one.
- R5: An accepted end of frame takes a copy of the count and clears the count. The copy is written into the current header slot, header-base is set to put, and the copy is also written at the new header slot. Put then advances by one. `q_pulse_o` is high for exactly one cycle, two cycles after the accepting edge.
- R6: `rx_irq_o` rises on the edge that ends each end-of-frame sequence. It stays high until a host read clears it.
- R7: A host read returns the RAM word at get. If get equals header-base, get is left unchanged and `rx_irq_o` is cleared. Otherwise get advances by one, so the host sees the length header followed by the data words of each packet.
- R8: `rd_valid_o` is high for exactly the cycle after each accepted read, and `rd_data_o` holds the word read at that time.
- R9: At most one of `rx_ack_o` and `rd_ack_o` is high in a cycle. A receive request wins over a host read, and a receive word wins over an end of frame. No request is acknowledged while an end-of-frame sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive word offered |
| rx_data_i | input | DW | Receive word |
| rx_eof_i | input | 1 | End of frame offered |
| rx_ack_o | output | 1 | Receive word or end of frame taken at this edge |
| rd_req_i | input | 1 | Host read request |
| rd_ack_o | output | 1 | Host read taken at this edge |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | DW | Read data |
| q_pulse_o | output | 1 | One-cycle pulse when a packet is completed |
| overflow_o | output | 1 | Sticky ring-full discard flag |
| rx_irq_o | output | 1 | Complete packet waiting |

## Verification
The vector walk feeds the block three kinds of frames: one with three words, one empty frame, and one with a single word. A read follows each frame, so the back-filled length header and the stale copy left in the reserved slot can be told apart from the data words. Reads that land on the reserved slot separate "no advance, clear interrupt" from a normal pop. Simultaneous receive and read requests show the priority order. Filling the ring with exactly 2^AW − 1 words brings put onto get. The discarded word and the discarded end of frame then show whether anything was written, because the reserved slot must still read back its old value.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_HDR_FILL = 2'd1,
    ST_HDR_RSV  = 2'd2
  } ring_st_e;

  typedef enum logic [1:0] {
    GR_NONE = 2'd0,
    GR_WORD = 2'd1,
    GR_EOF  = 2'd2,
    GR_READ = 2'd3
  } grant_e;
endpackage

// File: rtl/rx_ring_ram.sv
module rx_ring_ram #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o       <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/rx_ring_arb.sv
module rx_ring_arb
  import rx_ring_pkg::*;
(
  input  logic   idle_i,
  input  logic   word_req_i,
  input  logic   eof_req_i,
  input  logic   rd_req_i,
  output grant_e grant_o
);
  always_comb begin
    grant_o = GR_NONE;
    if (idle_i) begin
      if (word_req_i)     grant_o = GR_WORD;
      else if (eof_req_i) grant_o = GR_EOF;
      else if (rd_req_i)  grant_o = GR_READ;
    end
  end
endmodule

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_put_i,
  input  logic          inc_get_i,
  input  logic          load_base_i,
  output logic [AW-1:0] put_o,
  output logic [AW-1:0] get_o,
  output logic [AW-1:0] base_o,
  output logic          full_o,
  output logic          at_base_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] put_q, get_q, base_q, gap;

  // ring distance, wraps modulo 2^AW
  assign gap       = put_q - get_q;
  assign full_o    = (gap == '0);
  assign at_base_o = (get_q == base_q);
  assign put_o     = put_q;
  assign get_o     = get_q;
  assign base_o    = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      put_q  <= '0;
      get_q  <= '0;
      base_q <= '0;
    end else begin
      if (inc_put_i)   put_q  <= put_q + ONE;
      if (inc_get_i)   get_q  <= get_q + ONE;
      if (load_base_i) base_q <= put_q;
    end
  end
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rx_ring_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_eof_i,
  output logic          rx_ack_o,
  input  logic          rd_req_i,
  output logic          rd_ack_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          q_pulse_o,
  output logic          overflow_o,
  output logic          rx_irq_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  ring_st_e      state_q, state_d;
  grant_e        grant;
  logic          init_q;
  logic [AW-1:0] count_q, latch_q;
  logic [AW-1:0] put, get, base;
  logic          full, at_base;
  logic          take_word, take_eof, take_read, discard, rsv_cycle;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic          ovf_q, irq_q, rdv_q;

  rx_ring_arb u_arb (
    .idle_i     (state_q == ST_IDLE),
    .word_req_i (rx_valid_i),
    .eof_req_i  (rx_eof_i),
    .rd_req_i   (rd_req_i),
    .grant_o    (grant)
  );

  assign take_word = (grant == GR_WORD) && !full;
  assign take_eof  = (grant == GR_EOF)  && !full;
  assign take_read = (grant == GR_READ);
  assign discard   = ((grant == GR_WORD) || (grant == GR_EOF)) && full;
  assign rsv_cycle = (state_q == ST_HDR_RSV);

  rx_ring_ptr #(.AW(AW)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inc_put_i   (take_word || rsv_cycle),
    .inc_get_i   (take_read && !at_base),
    .load_base_i (rsv_cycle),
    .put_o       (put),
    .get_o       (get),
    .base_o      (base),
    .full_o      (full),
    .at_base_o   (at_base)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (take_eof) state_d = ST_HDR_FILL;
      ST_HDR_FILL: state_d = ST_HDR_RSV;
      ST_HDR_RSV:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // single RAM port shared by all sequences
  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = put;
    ram_wdata = rx_data_i;
    if (state_q == ST_HDR_FILL) begin
      ram_en    = 1'b1;
      ram_we    = 1'b1;
      ram_addr  = base;
      ram_wdata = DW'(latch_q);
    end else if (rsv_cycle) begin
      ram_en    = 1'b1;
      ram_we    = 1'b1;
      ram_addr  = put;
      ram_wdata = DW'(latch_q);
    end else if (take_word) begin
      ram_en = 1'b1;
      ram_we = 1'b1;
    end else if (take_read) begin
      ram_en   = 1'b1;
      ram_addr = get;
    end
  end

  rx_ring_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i   (clk_i),
    .en_i    (ram_en),
    .we_i    (ram_we),
    .addr_i  (ram_addr),
    .wdata_i (ram_wdata),
    .rdata_o (rd_data_o)
  );

  // reset enters the header sequence with a zero count: reserves slot 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR_FILL;
      init_q  <= 1'b1;
      count_q <= '0;
      latch_q <= '0;
      ovf_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rdv_q   <= take_read;
      if (rsv_cycle) init_q <= 1'b0;
      if (take_word) count_q <= count_q + ONE;
      if (take_eof) begin
        latch_q <= count_q;
        count_q <= '0;
      end
      if (discard) ovf_q <= 1'b1;
      if (rsv_cycle && !init_q)     irq_q <= 1'b1;
      else if (take_read && at_base) irq_q <= 1'b0;
    end
  end

  assign rx_ack_o   = (grant == GR_WORD) || (grant == GR_EOF);
  assign rd_ack_o   = take_read;
  assign rd_valid_o = rdv_q;
  assign q_pulse_o  = rsv_cycle && !init_q;
  assign overflow_o = ovf_q;
  assign rx_irq_o   = irq_q;
endmodule

// File: rtl/rx_ring_chk.sv
module rx_ring_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_valid_i,
  input logic rx_eof_i,
  input logic rx_ack_o,
  input logic rd_req_i,
  input logic rd_ack_o,
  input logic rd_valid_o,
  input logic q_pulse_o,
  input logic overflow_o,
  input logic rx_irq_o
);
  p_ack_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_ack_o, rd_ack_o}));

  p_rx_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i || rx_eof_i) && rd_req_i |-> !rd_ack_o);

  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  p_ovf_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(rx_ack_o));

  p_rd_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |=> rd_valid_o);

  p_pulse_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_pulse_o |=> !q_pulse_o);

  p_irq_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_pulse_o |=> rx_irq_o);

  p_irq_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_irq_o) |-> $past(rd_ack_o));
endmodule

bind rx_ring_mgr rx_ring_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .rx_eof_i   (rx_eof_i),
  .rx_ack_o   (rx_ack_o),
  .rd_req_i   (rd_req_i),
  .rd_ack_o   (rd_ack_o),
  .rd_valid_o (rd_valid_o),
  .q_pulse_o  (q_pulse_o),
  .overflow_o (overflow_o),
  .rx_irq_o   (rx_irq_o)
);

// File: tb/sim_rx_ring_mgr.sv
module sim_rx_ring_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int NVEC = 18;

  // {op, data, expected read data, expected irq}; op 0 word, 1 eof, 2 read
  localparam logic [34:0] VEC [NVEC] = '{
    {2'd2, 16'h0000, 16'h0000, 1'b0},
    {2'd0, 16'h1111, 16'h0000, 1'b0},
    {2'd0, 16'h2222, 16'h0000, 1'b0},
    {2'd0, 16'h3333, 16'h0000, 1'b0},
    {2'd1, 16'h0000, 16'h0000, 1'b1},
    {2'd2, 16'h0000, 16'h0003, 1'b1},
    {2'd2, 16'h0000, 16'h1111, 1'b1},
    {2'd2, 16'h0000, 16'h2222, 1'b1},
    {2'd2, 16'h0000, 16'h3333, 1'b1},
    {2'd2, 16'h0000, 16'h0003, 1'b0},
    {2'd1, 16'h0000, 16'h0000, 1'b1},
    {2'd2, 16'h0000, 16'h0000, 1'b1},
    {2'd2, 16'h0000, 16'h0000, 1'b0},
    {2'd0, 16'hABCD, 16'h0000, 1'b0},
    {2'd1, 16'h0000, 16'h0000, 1'b1},
    {2'd2, 16'h0000, 16'h0001, 1'b1},
    {2'd2, 16'h0000, 16'hABCD, 1'b1},
    {2'd2, 16'h0000, 16'h0001, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          rx_eof = 1'b0;
  logic          rx_ack;
  logic          rd_req = 1'b0;
  logic          rd_ack, rd_valid, q_pulse, overflow, rx_irq;
  logic [DW-1:0] rd_data;
  int            n_checks = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_mgr #(.AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_eof_i(rx_eof), .rx_ack_o(rx_ack),
    .rd_req_i(rd_req), .rd_ack_o(rd_ack), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .q_pulse_o(q_pulse), .overflow_o(overflow), .rx_irq_o(rx_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [DW-1:0] d);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = d;
    #1;
    while (!rx_ack) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_eof(output bit pulse_seen);
    @(negedge clk);
    rx_eof = 1'b1;
    #1;
    while (!rx_ack) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    rx_eof = 1'b0;
    pulse_seen = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (q_pulse) pulse_seen = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic do_read(output logic [DW-1:0] d, output logic irq);
    @(negedge clk);
    rd_req = 1'b1;
    #1;
    while (!rd_ack) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    check("R8 rd_valid after read", 32'(rd_valid), 32'd1);
    d   = rd_data;
    irq = rx_irq;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    logic          irq;
    bit            pulse;

    repeat (3) @(negedge clk);
    check("R1 overflow in reset", 32'(overflow), 32'd0);
    check("R1 irq in reset", 32'(rx_irq), 32'd0);
    rst_n = 1'b1;
    pulse = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (q_pulse) pulse = 1'b1;
      @(negedge clk);
    end
    check("R2 no pulse during init", 32'(pulse), 32'd0);
    check("R1 rd_valid idle", 32'(rd_valid), 32'd0);
    check("R2 no irq after init", 32'(rx_irq), 32'd0);

    // R4 R5 R6 R7: vector walk
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0]    op;
      logic [DW-1:0] vd, ve;
      logic          vi;
      {op, vd, ve, vi} = VEC[v];
      case (op)
        2'd0: send_word(vd);
        2'd1: begin
          send_eof(pulse);
          check($sformatf("R5 q_pulse vec %0d", v), 32'(pulse), 32'd1);
          check($sformatf("R6 irq set vec %0d", v), 32'(rx_irq), 32'(vi));
        end
        default: begin
          do_read(d, irq);
          check($sformatf("R7 R4 read data vec %0d", v), 32'(d), 32'(ve));
          check($sformatf("R7 irq after read vec %0d", v), 32'(irq), 32'(vi));
        end
      endcase
    end

    // R9: receive wins over host read
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = '0;
    rd_req   = 1'b1;
    #1;
    check("R9 rx ack on conflict", 32'(rx_ack), 32'd1);
    check("R9 no rd ack on conflict", 32'(rd_ack), 32'd0);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    rd_req   = 1'b0;

    // R3: fill until put reaches get (2^AW - 1 words in total)
    for (int i = 1; i < (1 << AW) - 1; i++) send_word(DW'(i));
    check("R3 no overflow before full", 32'(overflow), 32'd0);
    send_word(16'hDEAD);
    check("R3 overflow on full word", 32'(overflow), 32'd1);
    send_eof(pulse);
    check("R3 no pulse on full eof", 32'(pulse), 32'd0);
    check("R3 no irq on full eof", 32'(rx_irq), 32'd0);
    do_read(d, irq);
    check("R3 reserved slot untouched", 32'(d), 32'h0001);
    check("R3 overflow sticky", 32'(overflow), 32'd1);

    finish_run();
  end
endmodule